// File: doc/BRIEF.md
# Debug Hardware Breakpoint Comparators

This block watches the instruction fetch stream and the load/store stream of a processor pipeline. It compares each one against a set of programmable breakpoints. When a watched transaction matches an enabled breakpoint, the block raises a debug exception request one clock later. It also reports which breakpoint hit and sets a sticky status bit for that breakpoint. Debug software programs the comparators through a simple single-cycle register write port.

The block has two kinds of breakpoint:

- An instruction breakpoint compares the fetch address under a bit mask. It can also require a matching address space identifier (ASID).
- A data breakpoint does the same address and ASID compare. It can also require a load or a store, an allowed access size, and a data value. The value compare covers only the bytes the access touches and the byte mask keeps.

A build parameter selects the breakpoint set: four instruction plus two data breakpoints, two plus one, or none. The output ports always have the full width, and slots that are not built stay at zero.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: A valid fetch whose address equals an enabled instruction breakpoint's address on all unmasked bits sets that breakpoint's bit of `if_hit_o` and raises `if_dbg_req_o` in the cycle after the fetch; a cycle without `if_valid_i` (or `dt_valid_i` for data) produces no hit.
- R2: An address mask bit of 1 excludes that address bit from the compare, for both breakpoint kinds.
- R3: With the ASID-use control bit (ctrl bit 1) set, a hit also needs the transaction ASID to equal the stored ASID; with it clear, any ASID matches.
- R4: A breakpoint whose enable bit (ctrl bit 0) is clear never hits.
- R5: A data breakpoint hits on a load only if ctrl bit 2 is set, and on a store (`dt_store_i`=1) only if ctrl bit 3 is set; a data hit raises `dt_dbg_req_o` and the breakpoint's bit of `dt_hit_o` one cycle later.
- R6: Access size code 0 is byte, 1 is halfword and 2 is word; these are allowed by ctrl bits 4, 5 and 6 respectively, and size code 3 never hits.
- R7: With ctrl bit 7 set, a data hit also needs equal data on every byte lane the access touches that byte mask bit k does not exclude (1 excludes lane k). Lane k is data bits 8k+7..8k. A byte access touches lane addr[1:0], a halfword touches lanes 2..3 if addr[1] is 1 and otherwise lanes 0..1, and a word touches all four.
- R8: Each breakpoint's status bit is set by its hit, stays set, and is cleared by a write to field 7 of its slot.
- R9: `BP_SET`=2 builds 4 instruction and 2 data breakpoints, 1 builds 2 and 1, and 0 builds none; slots that are not built never hit and never set status.
- R10: A write sets the register selected by `wr_addr_i[6:4]` (slot 0..3 instruction, 4..5 data) and `wr_addr_i[2:0]` (0 address, 1 address mask, 2 ASID, 3 ctrl, 4 value, 5 byte mask, 7 status clear), and takes effect from the next cycle.
- R11: After reset all configuration, hit and status state is zero and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 7 | Slot and field select |
| wr_data_i | input | 32 | Write data |
| if_valid_i | input | 1 | Fetch transaction valid |
| if_addr_i | input | ADDR_W | Fetch virtual address |
| if_asid_i | input | ASID_W | Fetch ASID |
| dt_valid_i | input | 1 | Data transaction valid |
| dt_store_i | input | 1 | 1 store, 0 load |
| dt_size_i | input | 2 | Access size code |
| dt_addr_i | input | ADDR_W | Data virtual address |
| dt_asid_i | input | ASID_W | Data ASID |
| dt_data_i | input | 32 | Load or store data |
| if_hit_o | output | 4 | Per instruction breakpoint hit, registered |
| dt_hit_o | output | 2 | Per data breakpoint hit, registered |
| if_dbg_req_o | output | 1 | Instruction debug exception request |
| dt_dbg_req_o | output | 1 | Data debug exception request |
| ibp_status_o | output | 4 | Sticky instruction breakpoint status |
| dbp_status_o | output | 2 | Sticky data breakpoint status |

## Verification
Fetches are driven at exact addresses, at addresses that differ only inside a mask, and at addresses that differ outside it. This separates the masked compare from a plain equality. Fetches with matching and mismatching ASIDs, with ASID-use both on and off, show that the qualifier is optional. Data accesses of every size at several low address bits carry data that is wrong only in untouched or excluded lanes. This shows that the lane selection, not the full word, decides the value match. A second instance built with the smaller set sees the same traffic and must stay silent for the slots it lacks.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  localparam int unsigned MAX_IBP = 4;
  localparam int unsigned MAX_DBP = 2;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned SLOT_W  = 3;
  localparam int unsigned FLD_W   = 3;

  typedef enum logic [FLD_W-1:0] {
    FLD_ADDR  = 3'd0,
    FLD_AMASK = 3'd1,
    FLD_ASID  = 3'd2,
    FLD_CTRL  = 3'd3,
    FLD_VALUE = 3'd4,
    FLD_BMASK = 3'd5,
    FLD_CLR   = 3'd7
  } fld_e;

  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_ASID  = 1;
  localparam int unsigned CB_LOAD  = 2;
  localparam int unsigned CB_STORE = 3;
  localparam int unsigned CB_SZB   = 4;
  localparam int unsigned CB_SZH   = 5;
  localparam int unsigned CB_SZW   = 6;
  localparam int unsigned CB_VAL   = 7;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic logic [LANES-1:0] lanes_touched(logic [1:0] sz, logic [1:0] lo);
    case (sz)
      SZ_BYTE: return 4'b0001 << lo;
      SZ_HALF: return lo[1] ? 4'b1100 : 4'b0011;
      SZ_WORD: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/dbg_addr_match.sv
module dbg_addr_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ASID_W = 8
) (
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_mask_i,
  input  logic [ASID_W-1:0] cfg_asid_i,
  input  logic              cfg_asid_use_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              match_o
);
  logic addr_eq, asid_ok;
  // mask bit 1 drops that bit from the compare
  assign addr_eq = ~|((addr_i ^ cfg_addr_i) & ~cfg_mask_i);
  assign asid_ok = !cfg_asid_use_i || (asid_i == cfg_asid_i);
  assign match_o = addr_eq && asid_ok;
endmodule

// File: rtl/dbg_ibp_slot.sv
module dbg_ibp_slot
  import dbg_bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [FLD_W-1:0]  wr_fld_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              match_o
);
  logic [ADDR_W-1:0] addr_q, amask_q;
  logic [ASID_W-1:0] asid_q;
  logic              en_q, asid_use_q;
  logic              am;
  logic              unused_wr;

  assign unused_wr = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      amask_q    <= '0;
      asid_q     <= '0;
      en_q       <= 1'b0;
      asid_use_q <= 1'b0;
    end else if (wr_hit_i) begin
      case (wr_fld_i)
        FLD_ADDR:  addr_q  <= wr_data_i[ADDR_W-1:0];
        FLD_AMASK: amask_q <= wr_data_i[ADDR_W-1:0];
        FLD_ASID:  asid_q  <= wr_data_i[ASID_W-1:0];
        FLD_CTRL: begin
          en_q       <= wr_data_i[CB_EN];
          asid_use_q <= wr_data_i[CB_ASID];
        end
        default: ;
      endcase
    end
  end

  dbg_addr_match #(.ADDR_W(ADDR_W), .ASID_W(ASID_W)) i_am (
    .cfg_addr_i    (addr_q),
    .cfg_mask_i    (amask_q),
    .cfg_asid_i    (asid_q),
    .cfg_asid_use_i(asid_use_q),
    .addr_i        (addr_i),
    .asid_i        (asid_i),
    .match_o       (am)
  );

  assign match_o = en_q && am;

  AST_IBP_WR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_hit_i && wr_fld_i == FLD_ADDR) |-> addr_q == $past(wr_data_i[ADDR_W-1:0])); // R10
endmodule

// File: rtl/dbg_dbp_slot.sv
module dbg_dbp_slot
  import dbg_bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [FLD_W-1:0]  wr_fld_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              store_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              match_o
);
  logic [ADDR_W-1:0] addr_q, amask_q;
  logic [ASID_W-1:0] asid_q;
  logic [DATA_W-1:0] value_q;
  logic [LANES-1:0]  bmask_q;
  logic [7:0]        ctrl_q;
  logic              am, type_ok, size_ok, val_ok;
  logic [LANES-1:0]  lanes;
  logic              unused_wr;

  assign unused_wr = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      amask_q <= '0;
      asid_q  <= '0;
      value_q <= '0;
      bmask_q <= '0;
      ctrl_q  <= '0;
    end else if (wr_hit_i) begin
      case (wr_fld_i)
        FLD_ADDR:  addr_q  <= wr_data_i[ADDR_W-1:0];
        FLD_AMASK: amask_q <= wr_data_i[ADDR_W-1:0];
        FLD_ASID:  asid_q  <= wr_data_i[ASID_W-1:0];
        FLD_CTRL:  ctrl_q  <= wr_data_i[7:0];
        FLD_VALUE: value_q <= wr_data_i[DATA_W-1:0];
        FLD_BMASK: bmask_q <= wr_data_i[LANES-1:0];
        default: ;
      endcase
    end
  end

  dbg_addr_match #(.ADDR_W(ADDR_W), .ASID_W(ASID_W)) i_am (
    .cfg_addr_i    (addr_q),
    .cfg_mask_i    (amask_q),
    .cfg_asid_i    (asid_q),
    .cfg_asid_use_i(ctrl_q[CB_ASID]),
    .addr_i        (addr_i),
    .asid_i        (asid_i),
    .match_o       (am)
  );

  assign type_ok = store_i ? ctrl_q[CB_STORE] : ctrl_q[CB_LOAD];

  always_comb begin
    case (size_i)
      SZ_BYTE: size_ok = ctrl_q[CB_SZB];
      SZ_HALF: size_ok = ctrl_q[CB_SZH];
      SZ_WORD: size_ok = ctrl_q[CB_SZW];
      default: size_ok = 1'b0;
    endcase
  end

  assign lanes = lanes_touched(size_i, addr_i[1:0]);

  // only touched, unmasked lanes take part
  always_comb begin
    val_ok = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (lanes[k] && !bmask_q[k] && (data_i[8*k +: 8] != value_q[8*k +: 8]))
        val_ok = 1'b0;
    end
  end

  assign match_o = ctrl_q[CB_EN] && am && type_ok && size_ok && (!ctrl_q[CB_VAL] || val_ok);

  AST_DBP_WR_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_hit_i && wr_fld_i == FLD_VALUE) |-> value_q == $past(wr_data_i[DATA_W-1:0])); // R10
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
  import dbg_bkpt_pkg::*;
#(
  parameter int unsigned BP_SET = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ASID_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [6:0]          wr_addr_i,
  input  logic [31:0]         wr_data_i,
  input  logic                if_valid_i,
  input  logic [ADDR_W-1:0]   if_addr_i,
  input  logic [ASID_W-1:0]   if_asid_i,
  input  logic                dt_valid_i,
  input  logic                dt_store_i,
  input  logic [1:0]          dt_size_i,
  input  logic [ADDR_W-1:0]   dt_addr_i,
  input  logic [ASID_W-1:0]   dt_asid_i,
  input  logic [DATA_W-1:0]   dt_data_i,
  output logic [MAX_IBP-1:0]  if_hit_o,
  output logic [MAX_DBP-1:0]  dt_hit_o,
  output logic                if_dbg_req_o,
  output logic                dt_dbg_req_o,
  output logic [MAX_IBP-1:0]  ibp_status_o,
  output logic [MAX_DBP-1:0]  dbp_status_o
);
  localparam int unsigned NUM_IBP = (BP_SET == 2) ? 4 : (BP_SET == 1) ? 2 : 0;
  localparam int unsigned NUM_DBP = (BP_SET == 2) ? 2 : (BP_SET == 1) ? 1 : 0;

  logic [SLOT_W-1:0]  wr_slot;
  logic [FLD_W-1:0]   wr_fld;
  logic               unused_addr;
  logic [MAX_IBP-1:0] ibp_wr, ibp_clr, ibp_match, ibp_hit_d, ibp_hit_q, ibp_status_q;
  logic [MAX_DBP-1:0] dbp_wr, dbp_clr, dbp_match, dbp_hit_d, dbp_hit_q, dbp_status_q;

  assign wr_slot     = wr_addr_i[6:4];
  assign wr_fld      = wr_addr_i[2:0];
  assign unused_addr = wr_addr_i[3];

  always_comb begin
    for (int k = 0; k < MAX_IBP; k++) begin
      ibp_wr[k]  = wr_en_i && (wr_slot == SLOT_W'(k));
      ibp_clr[k] = ibp_wr[k] && (wr_fld == FLD_CLR);
    end
    for (int k = 0; k < MAX_DBP; k++) begin
      dbp_wr[k]  = wr_en_i && (wr_slot == SLOT_W'(MAX_IBP + k));
      dbp_clr[k] = dbp_wr[k] && (wr_fld == FLD_CLR);
    end
  end

  for (genvar k = 0; k < MAX_IBP; k++) begin : g_ibp
    if (k < NUM_IBP) begin : g_on
      dbg_ibp_slot #(.ADDR_W(ADDR_W), .ASID_W(ASID_W)) i_slot (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_hit_i (ibp_wr[k]),
        .wr_fld_i (wr_fld),
        .wr_data_i(wr_data_i),
        .addr_i   (if_addr_i),
        .asid_i   (if_asid_i),
        .match_o  (ibp_match[k])
      );
    end else begin : g_off
      assign ibp_match[k] = 1'b0;
    end
  end

  for (genvar k = 0; k < MAX_DBP; k++) begin : g_dbp
    if (k < NUM_DBP) begin : g_on
      dbg_dbp_slot #(.ADDR_W(ADDR_W), .ASID_W(ASID_W)) i_slot (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_hit_i (dbp_wr[k]),
        .wr_fld_i (wr_fld),
        .wr_data_i(wr_data_i),
        .addr_i   (dt_addr_i),
        .asid_i   (dt_asid_i),
        .store_i  (dt_store_i),
        .size_i   (dt_size_i),
        .data_i   (dt_data_i),
        .match_o  (dbp_match[k])
      );
    end else begin : g_off
      assign dbp_match[k] = 1'b0;
    end
  end

  assign ibp_hit_d = ibp_match & {MAX_IBP{if_valid_i}};
  assign dbp_hit_d = dbp_match & {MAX_DBP{dt_valid_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibp_hit_q    <= '0;
      dbp_hit_q    <= '0;
      ibp_status_q <= '0;
      dbp_status_q <= '0;
    end else begin
      ibp_hit_q    <= ibp_hit_d;
      dbp_hit_q    <= dbp_hit_d;
      // a hit in the clearing cycle wins
      ibp_status_q <= (ibp_status_q & ~ibp_clr) | ibp_hit_d;
      dbp_status_q <= (dbp_status_q & ~dbp_clr) | dbp_hit_d;
    end
  end

  assign if_hit_o     = ibp_hit_q;
  assign dt_hit_o     = dbp_hit_q;
  assign if_dbg_req_o = |ibp_hit_q;
  assign dt_dbg_req_o = |dbp_hit_q;
  assign ibp_status_o = ibp_status_q;
  assign dbp_status_o = dbp_status_q;

  AST_IF_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_hit_o != '0) |-> $past(if_valid_i)); // R1
  AST_DT_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dt_hit_o != '0) |-> $past(dt_valid_i)); // R5
  AST_SIZE3_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dt_valid_i && dt_size_i == 2'd3) |-> (dt_hit_o == '0)); // R6

  for (genvar k = 0; k < MAX_IBP; k++) begin : g_ibp_chk
    AST_IBP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(ibp_status_o[k] && !ibp_clr[k]) |-> ibp_status_o[k]); // R8
    AST_IBP_HIT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      if_hit_o[k] |-> ibp_status_o[k]); // R8
  end
  for (genvar k = 0; k < MAX_DBP; k++) begin : g_dbp_chk
    AST_DBP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(dbp_status_o[k] && !dbp_clr[k]) |-> dbp_status_o[k]); // R8
  end
endmodule

// File: tb/test_dbg_bkpt_unit.sv
module test_dbg_bkpt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        if_valid = 1'b0;
  logic [31:0] if_addr = '0;
  logic [7:0]  if_asid = '0;
  logic        dt_valid = 1'b0;
  logic        dt_store = 1'b0;
  logic [1:0]  dt_size = '0;
  logic [31:0] dt_addr = '0;
  logic [7:0]  dt_asid = '0;
  logic [31:0] dt_data = '0;
  logic [3:0]  if_hit, s_if_hit, ibp_st, s_ibp_st;
  logic [1:0]  dt_hit, s_dt_hit, dbp_st, s_dbp_st;
  logic        if_req, dt_req, s_if_req, s_dt_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] ih;
    logic [1:0] dh;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  dbg_bkpt_unit i_dbg_bkpt_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .if_valid_i(if_valid), .if_addr_i(if_addr), .if_asid_i(if_asid),
    .dt_valid_i(dt_valid), .dt_store_i(dt_store), .dt_size_i(dt_size), .dt_addr_i(dt_addr),
    .dt_asid_i(dt_asid), .dt_data_i(dt_data),
    .if_hit_o(if_hit), .dt_hit_o(dt_hit), .if_dbg_req_o(if_req), .dt_dbg_req_o(dt_req),
    .ibp_status_o(ibp_st), .dbp_status_o(dbp_st)
  );

  dbg_bkpt_unit #(.BP_SET(1)) i_dbg_bkpt_unit_min (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .if_valid_i(if_valid), .if_addr_i(if_addr), .if_asid_i(if_asid),
    .dt_valid_i(dt_valid), .dt_store_i(dt_store), .dt_size_i(dt_size), .dt_addr_i(dt_addr),
    .dt_asid_i(dt_asid), .dt_data_i(dt_data),
    .if_hit_o(s_if_hit), .dt_hit_o(s_dt_hit), .if_dbg_req_o(s_if_req), .dt_dbg_req_o(s_dt_req),
    .ibp_status_o(s_ibp_st), .dbp_status_o(s_dbp_st)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: one registered result per pushed transaction
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      logic [3:0] sih;
      logic [1:0] sdh;
      e = q.pop_front();
      sih = e.ih & 4'b0011;  // R9 small set keeps slots 0,1 and 4
      sdh = e.dh & 2'b01;
      check({e.tag, " hits"}, {20'd0, if_hit, dt_hit, if_req, dt_req, s_if_hit, s_dt_hit},
            {20'd0, e.ih, e.dh, |e.ih, |e.dh, sih, sdh});
    end
  end

  task automatic wr(int slot, int fld, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = {slot[2:0], 1'b0, fld[2:0]};
    wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic fetch(logic [31:0] a, logic [7:0] asid, logic [3:0] ih, string tag);
    @(negedge clk);
    if_valid = 1'b1;
    if_addr = a;
    if_asid = asid;
    q.push_back('{ih: ih, dh: 2'b00, tag: tag});
    @(posedge clk);
    #1 if_valid = 1'b0;
  endtask

  task automatic data(logic st, logic [1:0] sz, logic [31:0] a, logic [7:0] asid,
                      logic [31:0] d, logic [1:0] dh, string tag);
    @(negedge clk);
    dt_valid = 1'b1;
    dt_store = st;
    dt_size = sz;
    dt_addr = a;
    dt_asid = asid;
    dt_data = d;
    q.push_back('{ih: 4'b0000, dh: dh, tag: tag});
    @(posedge clk);
    #1 dt_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #5;
    check("R11 reset outputs", {20'd0, if_hit, dt_hit, if_req, dt_req, ibp_st, dbp_st}, 32'd0);

    // R10 programming through the register map
    wr(0, 0, 32'h0000_1000); wr(0, 3, 32'h1);
    wr(1, 0, 32'h0000_2000); wr(1, 1, 32'h0000_00FF); wr(1, 3, 32'h1);
    wr(2, 0, 32'h0000_3000); wr(2, 2, 32'h5); wr(2, 3, 32'h3);
    wr(3, 0, 32'h0000_4000);
    // R1 exact compare
    fetch(32'h1000, 8'd0, 4'b0001, "R1 exact");
    fetch(32'h1004, 8'd0, 4'b0000, "R1 miss");
    // R2 mask
    fetch(32'h20A4, 8'd0, 4'b0010, "R2 masked bits");
    fetch(32'h2100, 8'd0, 4'b0000, "R2 unmasked bit");
    // R3 asid
    fetch(32'h3000, 8'd5, 4'b0100, "R3 asid equal");
    fetch(32'h3000, 8'd6, 4'b0000, "R3 asid differ");
    fetch(32'h1000, 8'd9, 4'b0001, "R3 asid unused");
    // R4 enable
    fetch(32'h4000, 8'd0, 4'b0000, "R4 disabled");
    wr(3, 3, 32'h1);
    fetch(32'h4000, 8'd0, 4'b1000, "R4 enabled");
    #6 check("R8 ibp status", {28'd0, ibp_st}, 32'hF);
    check("R9 small ibp status", {28'd0, s_ibp_st}, 32'h3);
    wr(1, 7, 32'h0);
    #6 check("R8 ibp clear", {28'd0, ibp_st}, 32'hD);
    fetch(32'h5555, 8'd0, 4'b0000, "R1 no match");
    #6 check("R8 ibp sticky", {28'd0, ibp_st}, 32'hD);

    // data breakpoint slot 4
    wr(4, 0, 32'h8000); wr(4, 1, 32'h3); wr(4, 4, 32'h4433_2211); wr(4, 3, 32'hFD);
    data(1'b0, 2'd2, 32'h8000, 8'd0, 32'h4433_2211, 2'b01, "R7 word equal");
    data(1'b0, 2'd2, 32'h8000, 8'd0, 32'h4433_2299, 2'b00, "R7 word differ");
    data(1'b1, 2'd0, 32'h8002, 8'd0, 32'hAA33_BBCC, 2'b01, "R7 byte lane2");
    data(1'b1, 2'd0, 32'h8001, 8'd0, 32'hAA33_BBCC, 2'b00, "R7 byte lane1");
    data(1'b0, 2'd1, 32'h8002, 8'd0, 32'h4433_5566, 2'b01, "R7 half upper");
    data(1'b0, 2'd1, 32'h8002, 8'd0, 32'h4400_5566, 2'b00, "R7 half upper differ");
    data(1'b0, 2'd1, 32'h8000, 8'd0, 32'h0000_2211, 2'b01, "R7 half lower");
    wr(4, 5, 32'h4);
    data(1'b0, 2'd2, 32'h8000, 8'd0, 32'h44FF_2211, 2'b01, "R7 lane excluded");
    data(1'b0, 2'd3, 32'h8000, 8'd0, 32'h4433_2211, 2'b00, "R6 size code 3");
    data(1'b0, 2'd2, 32'h8004, 8'd0, 32'h4433_2211, 2'b00, "R2 data addr outside mask");
    // data breakpoint slot 5
    wr(5, 0, 32'h9000); wr(5, 3, 32'h49);
    data(1'b1, 2'd2, 32'h9000, 8'd0, 32'h1234_5678, 2'b10, "R5 store");
    data(1'b0, 2'd2, 32'h9000, 8'd0, 32'h1234_5678, 2'b00, "R5 load rejected");
    data(1'b1, 2'd0, 32'h9000, 8'd0, 32'h0000_0078, 2'b00, "R6 byte rejected");
    wr(5, 2, 32'h7); wr(5, 3, 32'h4B);
    data(1'b1, 2'd2, 32'h9000, 8'd3, 32'h0, 2'b00, "R3 data asid differ");
    data(1'b1, 2'd2, 32'h9000, 8'd7, 32'h0, 2'b10, "R3 data asid equal");
    #6 check("R8 dbp status", {30'd0, dbp_st}, 32'h3);
    check("R9 small dbp status", {30'd0, s_dbp_st}, 32'h1);
    wr(5, 7, 32'h0);
    #6 check("R8 dbp clear", {30'd0, dbp_st}, 32'h1);

    repeat (3) @(posedge clk);
    check("R1 queue drained", q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule